// File: doc/BRIEF.md
# Batch Round-Robin Conversion Scheduler

This block decides which of eight virtual channels a single shared converter works on next. Software raises a request bit for a channel through a small register port. That port can overwrite a whole register, OR bits in, clear bits, or flip bits. One write can therefore request a single channel, or a group of four, without disturbing requests that other software threads own.

While idle, the scheduler watches the request bits. When any bit is set, it freezes all of them into a batch on one clock edge. It then drives the converter once per captured channel, lowest channel number first, using a one-cycle start pulse and a one-cycle done pulse.

Each completion clears that channel's request bit and sets its status bit on the same edge. Status bits gated by per-channel enables form one interrupt line. Enabling only the highest channel of a group therefore produces a single interrupt once the whole group is finished.

Top module: `conv_sched_top`

## Requirements
- R1: After reset, the request, enable and status registers read 0, `irq` is low and `conv_start` is low.
- R2: A write applies `reg_op` to the register selected by `reg_addr` (0 = request, 1 = enable, 2 = status, 3 = none, reads 0). The `reg_op` codes are 0 = overwrite with `reg_wdata`, 1 = OR with `reg_wdata`, 2 = clear the bits set in `reg_wdata`, 3 = XOR with `reg_wdata`. Bits not selected by a set, clear or toggle keep their value. `reg_rdata` combinationally shows the register selected by `reg_addr`.
- R3: When the scheduler is idle and any request bit is set, it captures all request bits on the next clock edge. The first `conv_start` pulse is visible in the cycle after that edge.
- R4: Within a batch, each captured channel gets exactly one start, in ascending channel order. `conv_chan` carries the channel number.
- R5: `conv_start` is high for one cycle only. No further start is issued until a `conv_done` pulse arrives. A `conv_done` pulse arriving while no conversion is outstanding has no effect.
- R6: On the edge that samples `conv_done` for an outstanding channel, that channel's request bit clears and its status bit sets.
- R7: A request bit set while a batch runs is not added to that batch. It is serviced by a new batch once the current one ends.
- R8: `irq` is high exactly when some channel has both its status bit and its enable bit set.
- R9: When a completion and a software clear of the same status bit fall on the same edge, the status bit ends up set.
- R10: If channels 0 to 3 are requested together and only channel 3 is enabled, `irq` stays low until channel 3 has completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register select for write and read |
| reg_op | input | 2 | Write operation: overwrite, set, clear, toggle |
| reg_wdata | input | 8 | Write data, one bit per channel |
| reg_rdata | output | 8 | Read data of the selected register |
| conv_start | output | 1 | One-cycle converter start pulse |
| conv_chan | output | 3 | Channel number of the conversion being started |
| conv_done | input | 1 | One-cycle converter completion pulse |
| irq | output | 1 | Combined interrupt request |

## Verification
Request patterns used are a single channel, a contiguous group of four, and a scattered pattern (0, 2, 5, 7). An ordering or skipping fault in the channel picker shows up on one of them. A late request set after the first start separates a live request vector from a frozen snapshot. A toggle on the request register shows that flipping bits launches a batch just as setting them does.

The converter is answered with latencies of 1, 3 and 6 cycles. That separates waiting for done from advancing on a fixed count. A stray done pulse while idle shows that an unsolicited completion is not retired. A status clear placed exactly on a completion edge decides which update has priority.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_SET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_TOGGLE = 2'd3
  } reg_op_e;

  localparam logic [1:0] ADDR_REQ  = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int KIND_PLAIN  = 0;
  localparam int KIND_RETIRE = 1;
  localparam int KIND_STICKY = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } sched_state_e;

endpackage

// File: rtl/sched_bitreg.sv
module sched_bitreg
  import sched_pkg::*;
#(
  parameter int W    = 8,
  parameter int KIND = KIND_PLAIN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_op_e      op,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_vec,
  output logic [W-1:0] q
);

  logic [W-1:0] q_q;
  logic [W-1:0] base;
  logic [W-1:0] sw_val;
  logic [W-1:0] q_d;
  logic         upd;

  // base value the software op works on
  generate
    if (KIND == KIND_RETIRE) begin : g_base_retire
      assign base = q_q & ~hw_vec;
    end else begin : g_base_plain
      assign base = q_q;
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_WRITE:  sw_val = wdata;
      OP_SET:    sw_val = base | wdata;
      OP_CLEAR:  sw_val = base & ~wdata;
      default:   sw_val = base ^ wdata;
    endcase
  end

  generate
    if (KIND == KIND_STICKY) begin : g_next_sticky
      // completion has priority over any software clear
      assign q_d = (wr_en ? sw_val : q_q) | hw_vec;
    end else begin : g_next_other
      assign q_d = wr_en ? sw_val : base;
    end
  endgenerate

  assign upd = wr_en | (|hw_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (upd) begin
      q_q <= q_d;
    end
  end

  assign q = q_q;

  generate
    if (KIND == KIND_STICKY) begin : g_chk_sticky
      p_hw_set_wins_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_vec) |=> ((q_q & $past(hw_vec)) == $past(hw_vec)));
    end else if (KIND == KIND_RETIRE) begin : g_chk_retire
      p_req_retire_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        ((|hw_vec) && !wr_en) |=> ((q_q & $past(hw_vec)) == '0));
    end else begin : g_chk_plain
      p_hold_no_write_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q_q));
    end
  endgenerate

endmodule

// File: rtl/sched_regs.sv
module sched_regs
  import sched_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [1:0]     reg_addr,
  input  reg_op_e        reg_op,
  input  logic [NCH-1:0] reg_wdata,
  input  logic [NCH-1:0] done_vec,
  output logic [NCH-1:0] req_q,
  output logic [NCH-1:0] en_q,
  output logic [NCH-1:0] stat_q,
  output logic [NCH-1:0] reg_rdata
);

  logic wr_req;
  logic wr_en;
  logic wr_stat;

  assign wr_req  = reg_wr && (reg_addr == ADDR_REQ);
  assign wr_en   = reg_wr && (reg_addr == ADDR_EN);
  assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);

  sched_bitreg #(.W(NCH), .KIND(KIND_RETIRE)) u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_req),
    .op     (reg_op),
    .wdata  (reg_wdata),
    .hw_vec (done_vec),
    .q      (req_q)
  );

  sched_bitreg #(.W(NCH), .KIND(KIND_PLAIN)) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .op     (reg_op),
    .wdata  (reg_wdata),
    .hw_vec ('0),
    .q      (en_q)
  );

  sched_bitreg #(.W(NCH), .KIND(KIND_STICKY)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_stat),
    .op     (reg_op),
    .wdata  (reg_wdata),
    .hw_vec (done_vec),
    .q      (stat_q)
  );

  always_comb begin
    unique case (reg_addr)
      ADDR_REQ:  reg_rdata = req_q;
      ADDR_EN:   reg_rdata = en_q;
      ADDR_STAT: reg_rdata = stat_q;
      default:   reg_rdata = '0;
    endcase
  end

  p_done_onehot_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_vec));

endmodule

// File: rtl/sched_fsm.sv
module sched_fsm
  import sched_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  input  logic           conv_done,
  output logic           conv_start,
  output logic [CW-1:0]  conv_chan,
  output logic [NCH-1:0] done_vec
);

  sched_state_e   state_q, state_d;
  logic [NCH-1:0] snap_q, snap_d;
  logic [CW-1:0]  cur;
  logic [NCH-1:0] cur_onehot;
  logic           finish;

  // lowest captured channel goes next
  always_comb begin
    cur = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (snap_q[i]) cur = CW'(i);
    end
  end

  always_comb begin
    cur_onehot = '0;
    cur_onehot[cur] = 1'b1;
  end

  assign finish = (state_q == ST_WAIT) && conv_done;

  always_comb begin
    state_d = state_q;
    snap_d  = snap_q;
    unique case (state_q)
      ST_IDLE: begin
        if (|req_i) begin
          snap_d  = req_i;
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (conv_done) begin
          snap_d  = snap_q & ~cur_onehot;
          state_d = ((snap_q & ~cur_onehot) == '0) ? ST_IDLE : ST_ISSUE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        snap_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      snap_q  <= '0;
    end else begin
      state_q <= state_d;
      snap_q  <= snap_d;
    end
  end

  assign conv_start = (state_q == ST_ISSUE);
  assign conv_chan  = cur;
  assign done_vec   = finish ? cur_onehot : '0;

  p_start_pulse_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_start_in_snap_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> snap_q[conv_chan]);

  p_snap_no_growth_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != ST_IDLE) && $past(state_q != ST_IDLE))
      |-> ((snap_q & ~$past(snap_q)) == '0));

endmodule

// File: rtl/conv_sched_top.sv
module conv_sched_top
  import sched_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [1:0]     reg_addr,
  input  logic [1:0]     reg_op,
  input  logic [NCH-1:0] reg_wdata,
  output logic [NCH-1:0] reg_rdata,
  output logic           conv_start,
  output logic [CW-1:0]  conv_chan,
  input  logic           conv_done,
  output logic           irq
);

  logic [NCH-1:0] req_q;
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] stat_q;
  logic [NCH-1:0] done_vec;

  sched_regs #(.NCH(NCH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_op    (reg_op_e'(reg_op)),
    .reg_wdata (reg_wdata),
    .done_vec  (done_vec),
    .req_q     (req_q),
    .en_q      (en_q),
    .stat_q    (stat_q),
    .reg_rdata (reg_rdata)
  );

  sched_fsm #(.NCH(NCH)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_q),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .done_vec   (done_vec)
  );

  assign irq = |(stat_q & en_q);

  p_irq_needs_status_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q != '0));

endmodule

// File: tb/sim_conv_sched_top.sv
module sim_conv_sched_top;

  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [1:0] reg_op;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       conv_start;
  logic [2:0] conv_chan;
  logic       conv_done;
  logic       irq;
  logic       mon_done;
  logic       stray_done;

  int checks;
  int errors;
  int conv_lat;
  int exp_q[$];

  assign conv_done = mon_done | stray_done;

  conv_sched_top u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_op     (reg_op),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .conv_done  (conv_done),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [1:0] o, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_op = o; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_batch();
    logic [7:0] v;
    do begin
      reg_read(2'd0, v);
    end while (v != 8'h00 || exp_q.size() != 0 || conv_start);
    repeat (4) @(negedge clk);
  endtask

  // converter model and scoreboard monitor
  initial begin
    mon_done = 1'b0;
    forever begin
      @(negedge clk);
      while (conv_start) begin
        if (exp_q.size() == 0) begin
          chk("R4 unexpected start", {29'd0, conv_chan}, 32'hFFFF_FFFF);
        end else begin
          chk("R4 channel order", {29'd0, conv_chan}, exp_q.pop_front());
        end
        @(negedge clk);
        chk("R5 start one cycle", {31'd0, conv_start}, 32'd0);
        repeat (conv_lat - 1) @(negedge clk);
        mon_done = 1'b1;
        @(negedge clk);
        mon_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int bad;
    checks = 0; errors = 0; conv_lat = 1;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_op = 2'd0; reg_wdata = 8'h00;
    stray_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(2'd0, v); chk("R1 request reset", v, 8'h00);
    reg_read(2'd1, v); chk("R1 enable reset", v, 8'h00);
    reg_read(2'd2, v); chk("R1 status reset", v, 8'h00);
    chk("R1 irq reset", irq, 1'b0);
    chk("R1 start reset", conv_start, 1'b0);

    // R2 register operations on enable register
    reg_write(2'd1, 2'd0, 8'hA5); reg_read(2'd1, v); chk("R2 overwrite", v, 8'hA5);
    reg_write(2'd1, 2'd1, 8'h0F); reg_read(2'd1, v); chk("R2 set", v, 8'hAF);
    reg_write(2'd1, 2'd2, 8'h81); reg_read(2'd1, v); chk("R2 clear", v, 8'h2E);
    reg_write(2'd1, 2'd3, 8'hFF); reg_read(2'd1, v); chk("R2 toggle", v, 8'hD1);
    reg_write(2'd3, 2'd0, 8'hFF); reg_read(2'd3, v); chk("R2 unused address", v, 8'h00);
    reg_write(2'd1, 2'd0, 8'h00);

    // R3 single channel latency, R6 retire
    conv_lat = 1;
    exp_q.push_back(4);
    reg_write(2'd0, 2'd1, 8'h10);
    @(negedge clk); #1;
    chk("R3 start after snapshot", conv_start, 1'b1);
    chk("R3 channel", conv_chan, 3'd4);
    wait_batch();
    reg_read(2'd2, v); chk("R6 status set", v, 8'h10);
    reg_read(2'd0, v); chk("R6 request cleared", v, 8'h00);
    reg_write(2'd2, 2'd0, 8'h00);
    reg_read(2'd2, v); chk("R2 status overwrite", v, 8'h00);

    // R10 ganged group of four, only channel 3 enabled
    conv_lat = 3;
    reg_write(2'd1, 2'd1, 8'h08);
    for (int c = 0; c < 4; c++) exp_q.push_back(c);
    reg_write(2'd0, 2'd1, 8'h0F);
    bad = 0;
    for (int k = 0; k < 200; k++) begin
      reg_read(2'd2, v);
      if (!v[3] && irq) bad++;
      if (v[3]) break;
    end
    chk("R10 irq held until last", bad, 0);
    chk("R8 irq after group", irq, 1'b1);
    wait_batch();
    reg_read(2'd2, v); chk("R6 group status", v, 8'h0F);
    reg_write(2'd1, 2'd2, 8'h08);
    #1 chk("R8 irq off when disabled", irq, 1'b0);
    reg_write(2'd2, 2'd0, 8'h00);

    // R4 scattered order, R7 late request
    reg_write(2'd1, 2'd0, 8'h00);
    exp_q.push_back(0); exp_q.push_back(2); exp_q.push_back(5); exp_q.push_back(7);
    reg_write(2'd0, 2'd1, 8'hA5);
    do @(negedge clk); while (!conv_start);
    exp_q.push_back(1);
    reg_write(2'd0, 2'd1, 8'h02);
    wait_batch();
    reg_read(2'd2, v); chk("R7 late channel serviced", v, 8'hA7);
    chk("R7 queue drained", exp_q.size(), 0);

    // R9 completion beats clear on the same edge
    conv_lat = 6;
    exp_q.push_back(6);
    reg_write(2'd0, 2'd1, 8'h40);
    repeat (6) @(negedge clk);
    reg_write(2'd2, 2'd2, 8'hFF);
    wait_batch();
    reg_read(2'd2, v); chk("R9 status kept", v, 8'h40);

    // R5 stray done while idle
    @(negedge clk); stray_done = 1'b1;
    @(negedge clk); stray_done = 1'b0;
    reg_read(2'd2, v); chk("R5 stray done status", v, 8'h40);
    reg_read(2'd0, v); chk("R5 stray done request", v, 8'h00);
    chk("R5 no start on stray done", conv_start, 1'b0);

    // R2 toggle on request launches a batch
    conv_lat = 2;
    exp_q.push_back(0); exp_q.push_back(7);
    reg_write(2'd0, 2'd3, 8'h81);
    wait_batch();
    reg_read(2'd2, v); chk("R2 toggle request batch", v, 8'hC1);
    chk("R4 queue drained", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule